// File: doc/BRIEF.md
# Multi-Hart Machine Timer Compare Unit

This block holds one free-running 64-bit time counter shared by every hart, and one 64-bit compare register for each hart. Each hart receives a level-sensitive timer interrupt. The interrupt is high while that hart's compare value is at or below the counter, and low while the compare value lies ahead of the counter.

Software reaches the registers over a 32-bit register bus. The bus uses a valid, write, address and write-data request, and returns read data one cycle after the request. Each compare register occupies its own 8-byte slot and is written one half at a time. The counter can be read but not written. The counter advances only on cycles where the tick-enable input is high, so any time-base prescaling is done outside the block.

The number of harts, the address width, the compare base and the time base are parameters. The parameters are checked during elaboration.

Top module: `hart_timer_cmp`

## Requirements
- R1: The counter resets to zero and increases by exactly one at each clock edge where `tick_en_i` is high. It holds its value at every other edge.
- R2: A read of the time base returns counter bits 31:0, and a read of the time base plus 4 returns bits 63:32. In both cases the value is the one held at the request edge, and it appears on `bus_rdata_o` in the following cycle.
- R3: `timer_irq_o[i]` is high exactly when compare register i is less than or equal to the counter, using an unsigned 64-bit comparison. The level follows a write to either half of the compare register, or a tick of the counter, in the cycle after that edge.
- R4: Compare register i is at the compare base plus 8·i. Offset 0 of the slot holds bits 31:0 and offset 4 holds bits 63:32. Writing one half leaves the other half unchanged, and both halves read back what was written.
- R5: All compare registers reset to zero, so after reset every interrupt output is high.
- R6: Writes to either counter word have no effect on the counter.
- R7: A read of an undecoded address returns zero. A read of a compare slot at an offset other than 0 or 4 also returns zero. Writes to any of these addresses change no register. `bus_rdata_o` is zero in any cycle that does not follow a read request.
- R8: A write to one hart's compare register leaves every other hart's compare register and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Counter advance enable |
| bus_valid_i | input | 1 | Bus request valid |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after a read request |
| timer_irq_o | output | NUM_HARTS | Per-hart timer interrupt level |

## Verification
The hardest situation to reach from the ports is a compare value that crosses the counter through a write to only one half of the register. This must happen while the other half already holds a value that places the compare in the future. The bench gets there in two writes. It first sets a nonzero high word, which drops the interrupt. It then clears the high word and writes a small low word, and checks that the interrupt rises at once with the counter standing still. A separate scenario holds the counter still, sets the compare a known number of ticks ahead, and then steps the counter one tick at a time. It expects the interrupt on exactly the last tick.

// File: rtl/htc_pkg.sv
package htc_pkg;
   localparam int WORD_W = 32;
   localparam int TIME_W = 64;

   typedef logic [TIME_W-1:0] tval_t;
   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [2:0] {
      SRC_NONE    = 3'd0,
      SRC_CMP_LO  = 3'd1,
      SRC_CMP_HI  = 3'd2,
      SRC_TIME_LO = 3'd3,
      SRC_TIME_HI = 3'd4
   } src_e;
endpackage

// File: rtl/htc_decode.sv
module htc_decode
   import htc_pkg::*;
#(
   parameter int NUM_HARTS = 2,
   parameter int ADDR_W    = 12,
   parameter int CMP_BASE  = 0,
   parameter int TIME_BASE = 256
) (
   input  logic [ADDR_W-1:0]    addr_i,
   output src_e                 src_o,
   output logic [NUM_HARTS-1:0] hart_oh_o
);
   localparam logic [ADDR_W-1:0] CmpBase  = ADDR_W'(CMP_BASE);
   localparam logic [ADDR_W-1:0] CmpLimit = ADDR_W'(NUM_HARTS * 8);
   localparam logic [ADDR_W-1:0] TimeBase = ADDR_W'(TIME_BASE);

   logic [ADDR_W-1:0] rel;
   logic              in_cmp;

   assign rel    = addr_i - CmpBase;
   assign in_cmp = (addr_i >= CmpBase) && (rel < CmpLimit);

   for (genvar i = 0; i < NUM_HARTS; i++) begin : g_sel
      assign hart_oh_o[i] = in_cmp && (rel[ADDR_W-1:3] == (ADDR_W-3)'(i));
   end

   always_comb begin
      src_o = SRC_NONE;
      if (in_cmp) begin
         if (rel[2:0] == 3'd0)      src_o = SRC_CMP_LO;
         else if (rel[2:0] == 3'd4) src_o = SRC_CMP_HI;
      end else if (addr_i == TimeBase) begin
         src_o = SRC_TIME_LO;
      end else if (addr_i == TimeBase + ADDR_W'(4)) begin
         src_o = SRC_TIME_HI;
      end
   end
endmodule

// File: rtl/htc_counter.sv
module htc_counter
   import htc_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  tick_en_i,
   output tval_t time_o
);
   tval_t cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        cnt_q <= '0;
      else if (tick_en_i) cnt_q <= cnt_q + tval_t'(1);
   end

   assign time_o = cnt_q;
endmodule

// File: rtl/htc_cmp_slot.sv
module htc_cmp_slot
   import htc_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  wr_lo_i,
   input  logic  wr_hi_i,
   input  word_t wdata_i,
   input  tval_t time_i,
   output tval_t cmp_o,
   output logic  irq_o
);
   tval_t cmp_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cmp_q <= '0;
      end else begin
         if (wr_lo_i) cmp_q[WORD_W-1:0]      <= wdata_i;
         if (wr_hi_i) cmp_q[TIME_W-1:WORD_W] <= wdata_i;
      end
   end

   assign cmp_o = cmp_q;
   assign irq_o = (cmp_q <= time_i);
endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
   import htc_pkg::*;
#(
   parameter int NUM_HARTS = 2,
   parameter int ADDR_W    = 12,
   parameter int CMP_BASE  = 0,
   parameter int TIME_BASE = 256
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 tick_en_i,
   input  logic                 bus_valid_i,
   input  logic                 bus_write_i,
   input  logic [ADDR_W-1:0]    bus_addr_i,
   input  logic [31:0]          bus_wdata_i,
   output logic [31:0]          bus_rdata_o,
   output logic [NUM_HARTS-1:0] timer_irq_o
);
   localparam int CmpEnd = CMP_BASE + NUM_HARTS * 8;

   if (NUM_HARTS < 1) begin : g_bad_harts
      $error("NUM_HARTS must be at least 1");
   end
   if ((CMP_BASE % 8) != 0 || (TIME_BASE % 8) != 0) begin : g_bad_align
      $error("CMP_BASE and TIME_BASE must be 8-byte aligned");
   end
   if (TIME_BASE < CmpEnd && TIME_BASE + 8 > CMP_BASE) begin : g_bad_overlap
      $error("time window overlaps compare window");
   end
   if (CmpEnd > (1 << ADDR_W) || TIME_BASE + 8 > (1 << ADDR_W)) begin : g_bad_width
      $error("ADDR_W too small for the register windows");
   end

   src_e                         src;
   logic [NUM_HARTS-1:0]         hart_oh;
   tval_t                        time_q;
   logic [NUM_HARTS-1:0][63:0]   cmp_all;
   word_t                        rd_word;
   word_t                        rdata_q;
   logic                         do_wr;

   htc_decode #(
      .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W),
      .CMP_BASE(CMP_BASE), .TIME_BASE(TIME_BASE)
   ) decode_i (
      .addr_i    (bus_addr_i),
      .src_o     (src),
      .hart_oh_o (hart_oh)
   );

   htc_counter counter_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_en_i (tick_en_i),
      .time_o    (time_q)
   );

   assign do_wr = bus_valid_i && bus_write_i;

   for (genvar i = 0; i < NUM_HARTS; i++) begin : g_slot
      htc_cmp_slot slot_i (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .wr_lo_i (do_wr && hart_oh[i] && (src == SRC_CMP_LO)),
         .wr_hi_i (do_wr && hart_oh[i] && (src == SRC_CMP_HI)),
         .wdata_i (bus_wdata_i),
         .time_i  (time_q),
         .cmp_o   (cmp_all[i]),
         .irq_o   (timer_irq_o[i])
      );
   end

   always_comb begin
      tval_t sel_cmp;
      sel_cmp = '0;
      for (int i = 0; i < NUM_HARTS; i++) begin
         if (hart_oh[i]) sel_cmp = sel_cmp | cmp_all[i];
      end
      case (src)
         SRC_CMP_LO:  rd_word = sel_cmp[WORD_W-1:0];
         SRC_CMP_HI:  rd_word = sel_cmp[TIME_W-1:WORD_W];
         SRC_TIME_LO: rd_word = time_q[WORD_W-1:0];
         SRC_TIME_HI: rd_word = time_q[TIME_W-1:WORD_W];
         default:     rd_word = '0;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)                          rdata_q <= '0;
      else if (bus_valid_i && !bus_write_i) rdata_q <= rd_word;
      else                                  rdata_q <= '0;
   end

   assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/htc_checker.sv
module htc_checker #(
   parameter int NUM_HARTS = 2,
   parameter int ADDR_W    = 12,
   parameter int TIME_BASE = 256
) (
   input logic                       clk_i,
   input logic                       rst_ni,
   input logic                       tick_en_i,
   input logic                       bus_valid_i,
   input logic                       bus_write_i,
   input logic [ADDR_W-1:0]          bus_addr_i,
   input logic [31:0]                bus_rdata_o,
   input logic [NUM_HARTS-1:0]       timer_irq_o,
   input logic [63:0]                time_q,
   input logic [NUM_HARTS-1:0][63:0] cmp_all
);
   localparam logic [ADDR_W-1:0] TimeLo = ADDR_W'(TIME_BASE);
   localparam logic [ADDR_W-1:0] TimeHi = ADDR_W'(TIME_BASE + 4);

   p_time_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_en_i |=> time_q == $past(time_q) + 64'd1);

   p_time_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_en_i |=> $stable(time_q));

   p_time_wr_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_valid_i && bus_write_i && !tick_en_i &&
       (bus_addr_i == TimeLo || bus_addr_i == TimeHi)) |=> $stable(time_q));

   p_cmp_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_valid_i && bus_write_i) |=> $stable(cmp_all));

   p_rdata_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(bus_valid_i && !bus_write_i) |=> bus_rdata_o == 32'd0);

   for (genvar i = 0; i < NUM_HARTS; i++) begin : g_irq
      p_irq_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(timer_irq_o[i]) |-> $past(tick_en_i || (bus_valid_i && bus_write_i)));

      p_irq_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(timer_irq_o[i]) |-> $past(bus_valid_i && bus_write_i));
   end
endmodule

bind hart_timer_cmp htc_checker #(
   .NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .TIME_BASE(TIME_BASE)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .tick_en_i   (tick_en_i),
   .bus_valid_i (bus_valid_i),
   .bus_write_i (bus_write_i),
   .bus_addr_i  (bus_addr_i),
   .bus_rdata_o (bus_rdata_o),
   .timer_irq_o (timer_irq_o),
   .time_q      (time_q),
   .cmp_all     (cmp_all)
);

// File: tb/hart_timer_cmp_tb_top.sv
module hart_timer_cmp_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NH         = 2;
   localparam int AW         = 12;
   localparam int CB         = 0;
   localparam int TB         = 256;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          valid = 1'b0;
   logic          write = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NH-1:0] irq;

   int   n_tests = 0;
   int   n_fail  = 0;
   logic done    = 1'b0;
   logic [63:0] exp_time = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hart_timer_cmp #(.NUM_HARTS(NH), .ADDR_W(AW), .CMP_BASE(CB), .TIME_BASE(TB)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick_en),
      .bus_valid_i(valid), .bus_write_i(write), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .timer_irq_o(irq)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      valid = 1'b0; write = 1'b0;
   endtask

   task automatic bus_rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      valid = 1'b1; write = 1'b0; addr = a;
      @(negedge clk);
      valid = 1'b0;
      d = rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
      exp_time = exp_time + 64'(n);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R7 rdata idle after reset", 64'(rdata), 64'd0);
      chk("R5 irq all high after reset", 64'(irq), 64'(2'b11));
      bus_rd(AW'(TB), d);     chk("R1 time zero after reset", 64'(d), 64'd0);
      bus_rd(AW'(CB + 8), d); chk("R5 cmp1 lo zero", 64'(d), 64'd0);
      bus_rd(AW'(CB + 12), d); chk("R5 cmp1 hi zero", 64'(d), 64'd0);
   endtask

   task automatic t_cmp_rw();
      logic [31:0] d;
      bus_wr(AW'(CB + 4), 32'h1);
      chk("R3 irq0 low for future compare", 64'(irq[0]), 64'd0);
      chk("R8 irq1 untouched", 64'(irq[1]), 64'd1);
      bus_wr(AW'(CB + 0), 32'h0000_ABCD);
      bus_rd(AW'(CB + 0), d); chk("R4 cmp0 lo readback", 64'(d), 64'h0000_ABCD);
      bus_rd(AW'(CB + 4), d); chk("R4 cmp0 hi kept", 64'(d), 64'h1);
      bus_rd(AW'(CB + 8), d); chk("R8 cmp1 lo untouched", 64'(d), 64'd0);
   endtask

   task automatic t_tick_cross();
      logic [31:0] d;
      bus_wr(AW'(CB + 8), 32'(exp_time) + 32'd5);
      chk("R3 irq1 low before target", 64'(irq[1]), 64'd0);
      ticks(4);
      chk("R3 irq1 still low one tick early", 64'(irq[1]), 64'd0);
      ticks(1);
      chk("R3 irq1 high on reaching compare", 64'(irq[1]), 64'd1);
      bus_rd(AW'(TB), d);     chk("R2 time lo", 64'(d), 64'(exp_time[31:0]));
      bus_rd(AW'(TB + 4), d); chk("R2 time hi", 64'(d), 64'(exp_time[63:32]));
      ticks(3);
      bus_rd(AW'(TB), d);     chk("R1 time after more ticks", 64'(d), 64'(exp_time[31:0]));
   endtask

   task automatic t_time_write();
      logic [31:0] d;
      bus_wr(AW'(TB), 32'hFFFF_0000);
      bus_wr(AW'(TB + 4), 32'h1234_5678);
      bus_rd(AW'(TB), d);     chk("R6 time lo unchanged", 64'(d), 64'(exp_time[31:0]));
      bus_rd(AW'(TB + 4), d); chk("R6 time hi unchanged", 64'(d), 64'(exp_time[63:32]));
   endtask

   task automatic t_undecoded();
      logic [31:0] d;
      bus_rd(AW'(CB + 2), d);   chk("R7 odd slot offset reads zero", 64'(d), 64'd0);
      bus_rd(AW'(12'h0F0), d);  chk("R7 undecoded reads zero", 64'(d), 64'd0);
      bus_rd(AW'(TB + 2), d);   chk("R7 time odd offset reads zero", 64'(d), 64'd0);
      bus_wr(AW'(CB + 2), 32'hDEAD_BEEF);
      bus_wr(AW'(12'h0F0), 32'hDEAD_BEEF);
      bus_rd(AW'(CB + 0), d);   chk("R7 cmp0 lo unaffected", 64'(d), 64'h0000_ABCD);
      bus_rd(AW'(CB + 4), d);   chk("R7 cmp0 hi unaffected", 64'(d), 64'h1);
      chk("R7 irq unaffected", 64'(irq), 64'(2'b10));
   endtask

   task automatic t_half_cross();
      logic [31:0] d;
      bus_wr(AW'(CB + 4), 32'h0);
      chk("R3 irq0 low, lo still ahead", 64'(irq[0]), 64'd0);
      bus_wr(AW'(CB + 0), 32'd3);
      chk("R3 irq0 rises on lo write into past", 64'(irq[0]), 64'd1);
      chk("R8 irq1 unchanged", 64'(irq[1]), 64'd1);
      bus_rd(AW'(CB + 0), d); chk("R4 cmp0 lo final", 64'(d), 64'd3);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_cmp_rw();
      t_tick_cross();
      t_time_write();
      t_undecoded();
      t_half_cross();
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule